// File: doc/BRIEF.md
# Transceiver interrupt status controller

This block keeps the interrupt status of a radio transceiver and decides whether its active operations (transmit, receive, channel assessment) may start. Five event flags are collected into a status word: PLL unlock, transmit done, receive done, channel assessment done and attention. Each flag has its own mask bit. A single active-low interrupt line is driven whenever a recorded flag is also enabled. Software reads the status word through a read strobe, and that read clears it. Masks are written through a separate write strobe.

A PLL unlock aborts the running operation at once. It also leaves a sticky abort condition behind: every later operation request is refused until software has read the status. The abort reports completion differently by operation type. An aborted transmit still raises its done flag, so an interrupt can still reach software when the unlock flag is masked. An aborted receive or channel assessment raises no done flag at all.

The block also covers power handling. After reset is released, a startup interval passes and then the attention flag is raised. From the ready state the transceiver can be put to sleep, and the attention input wakes it and raises the attention flag again. Reset overrides every state.

Top module: `xcvr_irq_ctrl`

## Requirements
- R1: The status word is ordered as follows: bit 0 PLL unlock, bit 1 transmit done, bit 2 receive done, bit 3 channel assessment done, bit 4 attention. `irq_n` is low exactly when some status bit and its mask bit are both 1. It follows a status change in the cycle after the clock edge that records the event.
- R2: Out of reset the mask is 5'b10000, so only attention is enabled. A `wr_stb` cycle loads the mask from `wr_data` at the next edge. A masked event is still recorded in the status word.
- R3: While reset is low the status word is zero, `irq_n` is high and `xcvr_ready` is low. Exactly STARTUP_CYCLES clock edges after reset is released, the attention bit is set and `xcvr_ready` rises. Requests made before then are answered with an abort pulse.
- R4: `rd_data` always shows the status word. A cycle with `rd_stb` high clears the word at the next edge. An event that arrives in that same cycle is kept set.
- R5: An operation is selected by `op_kind`: 0 transmit, 1 receive, 2 channel assessment. When `op_done` arrives while an operation is active, the done bit of that kind is set and the block returns to idle.
- R6: A `pll_unlock` while an operation is active does three things at the next edge: it gives a one-cycle `op_kill` pulse, clears `op_busy` and sets the unlock bit. An aborted transmit also sets the transmit done bit. An aborted receive or channel assessment sets no done bit.
- R7: After any `pll_unlock`, every request receives `op_abort` and not `op_accept` until a status read has been made. A request made in the same cycle as that read is still aborted. The first request after the read is accepted.
- R8: Requests are answered one cycle later, with either a one-cycle `op_accept` (after which `op_busy` is high) or a one-cycle `op_abort`, never both. A request is aborted in any of these cases: an operation is already active (that operation continues), `op_kind` is 3, or `pll_unlock` arrives in the same cycle.
- R9: `lp_enter` while ready and idle puts the block to sleep, and `xcvr_ready` drops. `lp_enter` while an operation is active is ignored. `attn_in` while asleep wakes the block and sets the attention bit. `attn_in` while awake has no effect on status.
- R10: Requests made while the block is asleep are answered with an abort pulse.
- R11: Reset taken while asleep clears the status word, restores the default mask and restarts the startup interval.
- R12: `op_done` with no active operation changes no status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_req | input | 1 | Operation request strobe |
| op_kind | input | 2 | Requested operation: 0 transmit, 1 receive, 2 channel assessment |
| op_done | input | 1 | Datapath reports the active operation finished |
| pll_unlock | input | 1 | PLL lost lock (strobe) |
| lp_enter | input | 1 | Request to enter the low-power state |
| attn_in | input | 1 | Attention/wake input |
| rd_stb | input | 1 | Status read strobe; clears the status word |
| wr_stb | input | 1 | Mask write strobe |
| wr_data | input | 5 | Mask value for a write |
| rd_data | output | 5 | Current status word |
| irq_n | output | 1 | Active-low interrupt request |
| op_accept | output | 1 | One-cycle pulse: request accepted |
| op_abort | output | 1 | One-cycle pulse: request refused |
| op_kill | output | 1 | One-cycle pulse: running operation aborted by unlock |
| op_busy | output | 1 | An operation is active |
| xcvr_ready | output | 1 | Startup done and not asleep |

## Verification
A status read that clears the word can land in the same cycle as a new event. Several collisions are provoked on purpose. One is an operation finishing exactly while `rd_stb` is high; the new done bit must survive the clear and hold `irq_n` low. Another is a request issued in the very cycle of the read that ends the sticky abort; that request must still be refused, and the following one must be accepted. A third is a request issued together with a `pll_unlock`; it must be refused.

// File: rtl/xcvr_irq_pkg.sv
package xcvr_irq_pkg;

    localparam int NUM_FLAGS   = 5;
    localparam int FLAG_UNLOCK = 0;
    localparam int FLAG_TX     = 1;
    localparam int FLAG_RX     = 2;
    localparam int FLAG_CCA    = 3;
    localparam int FLAG_ATTN   = 4;

    typedef logic [NUM_FLAGS-1:0] flags_t;

    localparam flags_t MASK_RESET = flags_t'(1) << FLAG_ATTN;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_TX   = 2'd1,
        ACT_RX   = 2'd2,
        ACT_CCA  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        PWR_START = 2'd0,
        PWR_READY = 2'd1,
        PWR_SLEEP = 2'd2
    } pwr_e;

    typedef struct packed {
        act_e act;
        logic sticky;
        logic accept;
        logic abort;
        logic kill;
    } opctl_t;

    typedef struct packed {
        flags_t status;
        flags_t mask;
    } stat_t;

endpackage

// File: rtl/xcvr_irq_pwr.sv
module xcvr_irq_pwr
    import xcvr_irq_pkg::*;
#(
    parameter int STARTUP_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_enter,
    input  logic attn_in,
    input  logic busy,
    output logic ready,
    output logic attn_evt
);

    localparam int CNT_W = $clog2(STARTUP_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STARTUP_CYCLES - 1);

    typedef struct packed {
        pwr_e             mode;
        logic [CNT_W-1:0] cnt;
    } pwr_t;

    pwr_t pwr_d, pwr_q;

    always_comb begin
        pwr_d    = pwr_q;
        attn_evt = 1'b0;
        case (pwr_q.mode)
            PWR_START: begin
                if (pwr_q.cnt == CNT_LAST) begin
                    pwr_d.mode = PWR_READY;
                    pwr_d.cnt  = '0;
                    attn_evt   = 1'b1;
                end else begin
                    pwr_d.cnt = pwr_q.cnt + 1'b1;
                end
            end
            PWR_READY: begin
                if (lp_enter && !busy) begin
                    pwr_d.mode = PWR_SLEEP;
                end
            end
            PWR_SLEEP: begin
                if (attn_in) begin
                    pwr_d.mode = PWR_READY;
                    attn_evt   = 1'b1;
                end
            end
            default: pwr_d.mode = PWR_START;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q.mode <= PWR_START;
            pwr_q.cnt  <= '0;
        end else begin
            pwr_q <= pwr_d;
        end
    end

    assign ready = (pwr_q.mode == PWR_READY);

endmodule

// File: rtl/xcvr_irq_opctl.sv
module xcvr_irq_opctl
    import xcvr_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ready,
    input  logic       op_req,
    input  logic [1:0] op_kind,
    input  logic       op_done,
    input  logic       pll_unlock,
    input  logic       rd_stb,
    output logic       op_accept,
    output logic       op_abort,
    output logic       op_kill,
    output logic       op_busy,
    output logic       tx_evt,
    output logic       rx_evt,
    output logic       cca_evt
);

    opctl_t op_d, op_q;
    act_e   req_act;
    logic   req_ok;

    always_comb begin
        case (op_kind)
            2'd0:    req_act = ACT_TX;
            2'd1:    req_act = ACT_RX;
            2'd2:    req_act = ACT_CCA;
            default: req_act = ACT_IDLE;
        endcase
    end

    always_comb begin
        op_d        = op_q;
        op_d.accept = 1'b0;
        op_d.abort  = 1'b0;
        op_d.kill   = 1'b0;
        tx_evt      = 1'b0;
        rx_evt      = 1'b0;
        cca_evt     = 1'b0;

        // sticky abort: set by unlock, released by a status read
        if (pll_unlock) begin
            op_d.sticky = 1'b1;
        end else if (rd_stb) begin
            op_d.sticky = 1'b0;
        end

        // running operation: unlock beats normal completion
        if (op_q.act != ACT_IDLE) begin
            if (pll_unlock) begin
                op_d.kill = 1'b1;
                op_d.act  = ACT_IDLE;
                tx_evt    = (op_q.act == ACT_TX);
            end else if (op_done) begin
                op_d.act = ACT_IDLE;
                tx_evt   = (op_q.act == ACT_TX);
                rx_evt   = (op_q.act == ACT_RX);
                cca_evt  = (op_q.act == ACT_CCA);
            end
        end

        // new request: judged against the pre-read sticky value
        req_ok = (op_q.act == ACT_IDLE) && ready && !op_q.sticky &&
                 !pll_unlock && (req_act != ACT_IDLE);
        if (op_req) begin
            if (req_ok) begin
                op_d.accept = 1'b1;
                op_d.act    = req_act;
            end else begin
                op_d.abort = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q.act    <= ACT_IDLE;
            op_q.sticky <= 1'b0;
            op_q.accept <= 1'b0;
            op_q.abort  <= 1'b0;
            op_q.kill   <= 1'b0;
        end else begin
            op_q <= op_d;
        end
    end

    assign op_accept = op_q.accept;
    assign op_abort  = op_q.abort;
    assign op_kill   = op_q.kill;
    assign op_busy   = (op_q.act != ACT_IDLE);

endmodule

// File: rtl/xcvr_irq_status.sv
module xcvr_irq_status
    import xcvr_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  flags_t evt,
    input  logic   rd_stb,
    input  logic   wr_stb,
    input  flags_t wr_data,
    output flags_t status,
    output flags_t mask
);

    stat_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.status = (rd_stb ? '0 : st_q.status) | evt;
        if (wr_stb) begin
            st_d.mask = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status <= '0;
            st_q.mask   <= MASK_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q.status;
    assign mask   = st_q.mask;

endmodule

// File: rtl/xcvr_irq_ctrl.sv
module xcvr_irq_ctrl
    import xcvr_irq_pkg::*;
#(
    parameter int STARTUP_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_req,
    input  logic [1:0] op_kind,
    input  logic       op_done,
    input  logic       pll_unlock,
    input  logic       lp_enter,
    input  logic       attn_in,
    input  logic       rd_stb,
    input  logic       wr_stb,
    input  logic [4:0] wr_data,
    output logic [4:0] rd_data,
    output logic       irq_n,
    output logic       op_accept,
    output logic       op_abort,
    output logic       op_kill,
    output logic       op_busy,
    output logic       xcvr_ready
);

    logic   attn_evt;
    logic   tx_evt;
    logic   rx_evt;
    logic   cca_evt;
    logic   busy;
    logic   ready;
    flags_t evt;
    flags_t status;
    flags_t mask;

    xcvr_irq_pwr #(
        .STARTUP_CYCLES(STARTUP_CYCLES)
    ) u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .lp_enter (lp_enter),
        .attn_in  (attn_in),
        .busy     (busy),
        .ready    (ready),
        .attn_evt (attn_evt)
    );

    xcvr_irq_opctl u_opctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready      (ready),
        .op_req     (op_req),
        .op_kind    (op_kind),
        .op_done    (op_done),
        .pll_unlock (pll_unlock),
        .rd_stb     (rd_stb),
        .op_accept  (op_accept),
        .op_abort   (op_abort),
        .op_kill    (op_kill),
        .op_busy    (busy),
        .tx_evt     (tx_evt),
        .rx_evt     (rx_evt),
        .cca_evt    (cca_evt)
    );

    always_comb begin
        evt              = '0;
        evt[FLAG_UNLOCK] = pll_unlock;
        evt[FLAG_TX]     = tx_evt;
        evt[FLAG_RX]     = rx_evt;
        evt[FLAG_CCA]    = cca_evt;
        evt[FLAG_ATTN]   = attn_evt;
    end

    xcvr_irq_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .status  (status),
        .mask    (mask)
    );

    assign rd_data    = status;
    assign irq_n      = ~|(status & mask);
    assign op_busy    = busy;
    assign xcvr_ready = ready;

endmodule

// File: rtl/xcvr_irq_ctrl_chk.sv
module xcvr_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_req,
    input logic       op_done,
    input logic       pll_unlock,
    input logic       attn_in,
    input logic       rd_stb,
    input logic [4:0] rd_data,
    input logic       irq_n,
    input logic       op_accept,
    input logic       op_abort,
    input logic       op_busy,
    input logic       xcvr_ready
);

    assert_accept_abort_excl_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        !(op_accept && op_abort)
    );

    assert_unlock_blocks_accept_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        pll_unlock |=> !op_accept
    );

    assert_unlock_kills_op_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (pll_unlock && op_busy) |=> (!op_busy && rd_data[0])
    );

    assert_not_ready_aborts_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (op_req && !xcvr_ready) |=> op_abort
    );

    assert_read_clears_irq_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (rd_stb && !pll_unlock && !op_done && !attn_in && xcvr_ready) |=> irq_n
    );

endmodule

bind xcvr_irq_ctrl xcvr_irq_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_req     (op_req),
    .op_done    (op_done),
    .pll_unlock (pll_unlock),
    .attn_in    (attn_in),
    .rd_stb     (rd_stb),
    .rd_data    (rd_data),
    .irq_n      (irq_n),
    .op_accept  (op_accept),
    .op_abort   (op_abort),
    .op_busy    (op_busy),
    .xcvr_ready (xcvr_ready)
);

// File: tb/xcvr_irq_ctrl_test.sv
`timescale 1ns/1ps
module xcvr_irq_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int STARTUP    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_req = 1'b0;
    logic [1:0] op_kind = 2'd0;
    logic       op_done = 1'b0;
    logic       pll_unlock = 1'b0;
    logic       lp_enter = 1'b0;
    logic       attn_in = 1'b0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [4:0] wr_data = 5'd0;
    logic [4:0] rd_data;
    logic       irq_n;
    logic       op_accept;
    logic       op_abort;
    logic       op_kill;
    logic       op_busy;
    logic       xcvr_ready;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcvr_irq_ctrl #(.STARTUP_CYCLES(STARTUP)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_req     (op_req),
        .op_kind    (op_kind),
        .op_done    (op_done),
        .pll_unlock (pll_unlock),
        .lp_enter   (lp_enter),
        .attn_in    (attn_in),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .irq_n      (irq_n),
        .op_accept  (op_accept),
        .op_abort   (op_abort),
        .op_kill    (op_kill),
        .op_busy    (op_busy),
        .xcvr_ready (xcvr_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic read_status(output logic [4:0] v);
        @(negedge clk);
        rd_stb = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_stb = 1'b0;
        #1;
    endtask

    task automatic write_mask(input logic [4:0] m);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = m;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic request(input logic [1:0] kind, output logic acc, output logic abt);
        @(negedge clk);
        op_req  = 1'b1;
        op_kind = kind;
        tick();
        acc = op_accept;
        abt = op_abort;
        @(negedge clk);
        op_req = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic pulse_unlock(output logic kill, output logic busy);
        @(negedge clk);
        pll_unlock = 1'b1;
        tick();
        kill = op_kill;
        busy = op_busy;
        @(negedge clk);
        pll_unlock = 1'b0;
    endtask

    task automatic pulse_pwr(input logic is_attn);
        @(negedge clk);
        if (is_attn) attn_in = 1'b1; else lp_enter = 1'b1;
        @(negedge clk);
        attn_in  = 1'b0;
        lp_enter = 1'b0;
    endtask

    // R3 / R2 / R11: reset state, startup timing, default mask
    task automatic t_reset_startup(input string tag);
        logic [4:0] v;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk({tag, " R3 reset status"}, 32'(rd_data), 32'h0);
        chk({tag, " R3 reset irq_n"}, 32'(irq_n), 32'h1);
        chk({tag, " R3 reset ready"}, 32'(xcvr_ready), 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 1; k <= STARTUP; k++) begin
            tick();
            if (k == 1) begin
                op_req  = 1'b1;
                op_kind = 2'd0;
            end
            if (k == 2) begin
                chk({tag, " R3 early request aborted"}, 32'(op_abort), 32'h1);
                op_req = 1'b0;
            end
            if (k == STARTUP - 1) begin
                chk({tag, " R3 irq before startup end"}, 32'(irq_n), 32'h1);
                chk({tag, " R3 not ready before end"}, 32'(xcvr_ready), 32'h0);
            end
        end
        chk({tag, " R3 attn irq at startup end"}, 32'(irq_n), 32'h0);
        chk({tag, " R3 ready at startup end"}, 32'(xcvr_ready), 32'h1);
        read_status(v);
        chk({tag, " R1 attn bit position"}, 32'(v), 32'h10);
        chk({tag, " R4 irq clears after read"}, 32'(irq_n), 32'h1);
    endtask

    task automatic t_mask();
        logic acc, abt;
        logic [4:0] v;
        write_mask(5'h00);
        request(2'd0, acc, abt);
        chk("R5 tx accepted", 32'(acc), 32'h1);
        pulse_done();
        #1;
        chk("R2 masked tx done keeps irq high", 32'(irq_n), 32'h1);
        read_status(v);
        chk("R2 masked event recorded", 32'(v), 32'h02);
        write_mask(5'h02);
        request(2'd0, acc, abt);
        pulse_done();
        #1;
        chk("R1 enabled tx done drives irq low", 32'(irq_n), 32'h0);
        read_status(v);
        chk("R5 tx done bit", 32'(v), 32'h02);
    endtask

    task automatic t_rx_cca_done();
        logic acc, abt;
        logic [4:0] v;
        write_mask(5'h1F);
        request(2'd1, acc, abt);
        chk("R8 rx accept pulse", 32'(acc), 32'h1);
        chk("R8 rx busy", 32'(op_busy), 32'h1);
        pulse_done();
        read_status(v);
        chk("R5 rx done bit", 32'(v), 32'h04);
        request(2'd2, acc, abt);
        pulse_done();
        #1;
        chk("R5 idle after done", 32'(op_busy), 32'h0);
        read_status(v);
        chk("R5 cca done bit", 32'(v), 32'h08);
    endtask

    task automatic t_unlock_abort();
        logic acc, abt, kill, busy;
        logic [4:0] v;
        write_mask(5'h02);
        request(2'd0, acc, abt);
        pulse_unlock(kill, busy);
        chk("R6 tx kill pulse", 32'(kill), 32'h1);
        chk("R6 tx idle after unlock", 32'(busy), 32'h0);
        #1;
        chk("R6 tx abort raises irq with unlock masked", 32'(irq_n), 32'h0);
        read_status(v);
        chk("R6 tx abort status", 32'(v), 32'h03);
        write_mask(5'h1F);
        request(2'd1, acc, abt);
        pulse_unlock(kill, busy);
        chk("R6 rx kill pulse", 32'(kill), 32'h1);
        read_status(v);
        chk("R6 rx abort no done bit", 32'(v), 32'h01);
        request(2'd2, acc, abt);
        chk("R7 cca accepted after read", 32'(acc), 32'h1);
        pulse_unlock(kill, busy);
        read_status(v);
        chk("R6 cca abort no done bit", 32'(v), 32'h01);
    endtask

    task automatic t_sticky();
        logic acc, abt, kill, busy;
        logic [4:0] v;
        pulse_unlock(kill, busy);
        chk("R6 no kill when idle", 32'(kill), 32'h0);
        request(2'd0, acc, abt);
        chk("R7 sticky abort", 32'(abt), 32'h1);
        chk("R7 sticky no accept", 32'(acc), 32'h0);
        chk("R7 sticky not busy", 32'(op_busy), 32'h0);
        request(2'd1, acc, abt);
        chk("R7 sticky abort again", 32'(abt), 32'h1);
        @(negedge clk);
        op_req  = 1'b1;
        op_kind = 2'd0;
        rd_stb  = 1'b1;
        #1 v = rd_data;
        chk("R7 status at clearing read", 32'(v), 32'h01);
        tick();
        chk("R7 request in read cycle aborted", 32'(op_abort), 32'h1);
        @(negedge clk);
        op_req = 1'b0;
        rd_stb = 1'b0;
        request(2'd0, acc, abt);
        chk("R7 accepted after read", 32'(acc), 32'h1);
        pulse_done();
        read_status(v);
        chk("R7 tx done after release", 32'(v), 32'h02);
        @(negedge clk);
        op_req     = 1'b1;
        op_kind    = 2'd0;
        pll_unlock = 1'b1;
        tick();
        chk("R8 request with unlock aborted", 32'(op_abort), 32'h1);
        @(negedge clk);
        op_req     = 1'b0;
        pll_unlock = 1'b0;
        read_status(v);
        chk("R8 unlock recorded", 32'(v), 32'h01);
    endtask

    task automatic t_busy_reject();
        logic acc, abt;
        logic [4:0] v;
        request(2'd1, acc, abt);
        request(2'd0, acc, abt);
        chk("R8 busy request aborted", 32'(abt), 32'h1);
        chk("R8 current op continues", 32'(op_busy), 32'h1);
        pulse_done();
        read_status(v);
        chk("R8 only rx done", 32'(v), 32'h04);
        request(2'd3, acc, abt);
        chk("R8 kind 3 aborted", 32'(abt), 32'h1);
        chk("R8 kind 3 no accept", 32'(acc), 32'h0);
    endtask

    task automatic t_read_collision();
        logic acc, abt;
        logic [4:0] v;
        request(2'd0, acc, abt);
        @(negedge clk);
        op_done = 1'b1;
        rd_stb  = 1'b1;
        #1;
        chk("R4 word empty before collision", 32'(rd_data), 32'h0);
        tick();
        chk("R4 done kept through clear", 32'(rd_data), 32'h02);
        chk("R4 irq low after collision", 32'(irq_n), 32'h0);
        @(negedge clk);
        op_done = 1'b0;
        rd_stb  = 1'b0;
        read_status(v);
        chk("R4 collided event readable", 32'(v), 32'h02);
        read_status(v);
        chk("R4 cleared", 32'(v), 32'h00);
    endtask

    task automatic t_idle_done();
        logic [4:0] v;
        pulse_done();
        #1;
        chk("R12 idle done irq", 32'(irq_n), 32'h1);
        read_status(v);
        chk("R12 idle done no status", 32'(v), 32'h00);
    endtask

    task automatic t_sleep();
        logic acc, abt;
        logic [4:0] v;
        pulse_pwr(1'b1);
        read_status(v);
        chk("R9 attn while awake ignored", 32'(v), 32'h00);
        request(2'd0, acc, abt);
        pulse_pwr(1'b0);
        #1;
        chk("R9 lp_enter ignored while busy", 32'(xcvr_ready), 32'h1);
        pulse_done();
        read_status(v);
        pulse_pwr(1'b0);
        #1;
        chk("R9 asleep", 32'(xcvr_ready), 32'h0);
        request(2'd1, acc, abt);
        chk("R10 sleep request aborted", 32'(abt), 32'h1);
        pulse_pwr(1'b1);
        #1;
        chk("R9 woken", 32'(xcvr_ready), 32'h1);
        chk("R9 wake irq", 32'(irq_n), 32'h0);
        read_status(v);
        chk("R9 wake sets attn", 32'(v), 32'h10);
        write_mask(5'h00);
        pulse_pwr(1'b0);
        pulse_pwr(1'b1);
        #1;
        chk("R2 wake with attn masked no irq", 32'(irq_n), 32'h1);
        read_status(v);
        chk("R2 masked wake recorded", 32'(v), 32'h10);
        pulse_pwr(1'b0);
        #1;
        chk("R11 asleep before reset", 32'(xcvr_ready), 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset_startup("first");
        t_mask();
        t_rx_cca_done();
        t_unlock_abort();
        t_sticky();
        t_busy_reject();
        t_read_collision();
        t_idle_done();
        t_sleep();
        t_reset_startup("R11 from sleep");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule